// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block merges a group of level-sensitive interrupt sources into one request line for a processor. Every source carries a programmable priority. Some sources are wired from peripherals. The rest are request flops that software sets and clears with strobes. A combinational arbiter picks the pending source with the highest priority. The request line is raised only when that priority is strictly above the processor's current priority.

The processor accepts an interrupt with an acknowledge read strobe. That read reports the winning source index. It also lifts the current priority to the winner's level and saves the previous level on a hardware last-in-first-out stack. When a handler finishes, an end-of-interrupt strobe restores the saved level from the top of the stack.

Neither the acknowledge nor the end-of-interrupt clears a source. A source stays pending until it is cleared where it came from. As a result, a request that was masked by a raised priority comes back by itself once the priority falls below it again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_req is low, cur_prio is 0, and both lifo_ovf and lifo_unf are low. All source priorities reset to 0 and all software request flops reset to 0.
- R2: irq_req is high exactly when at least one pending source has a priority strictly greater than cur_prio. A source with priority 0 never raises irq_req.
- R3: ack_vec gives the index of the pending source with the highest priority. When several sources share that priority, the lowest index wins.
- R4: A cycle with ack_rd high while irq_req is high has two effects. It pushes the old cur_prio onto the stack, and from the next cycle cur_prio equals the priority of the source that ack_vec named.
- R5: ack_rd while irq_req is low is ignored. cur_prio does not change and nothing is pushed.
- R6: An eoi strobe pops the top of the stack into cur_prio on the next clock. Nested levels come back in reverse order of their acknowledges.
- R7: eoi with an empty stack leaves cur_prio unchanged and sets lifo_unf. lifo_unf stays set until reset.
- R8: A push onto a full stack discards the pushed value and keeps the entries already stored. cur_prio is still raised. lifo_ovf is set and stays set until reset.
- R9: Acknowledging a source does not clear it. After an eoi lowers cur_prio below the priority of a still-pending source, irq_req goes high again.
- R10: Hardware sources are hw_irq bits 0 to N_SRC-N_SW-1. Software source k is source index N_SRC-N_SW+k, which is 12+k by default. sw_set[k] sets it and sw_clr[k] clears it on the next clock. When both strobes arrive in the same cycle, the set wins.
- R11: A cycle with prio_wr_en high loads prio_wr_val into the priority of source prio_wr_idx. The new value takes effect from the next cycle.
- R12: When ack_rd and eoi are high in the same cycle while irq_req is high, the acknowledge is carried out and the eoi is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | N_SRC-N_SW | Peripheral request levels |
| sw_set | input | N_SW | Single-cycle set strobes for the software sources |
| sw_clr | input | N_SW | Single-cycle clear strobes for the software sources |
| prio_wr_en | input | 1 | Priority write strobe |
| prio_wr_idx | input | $clog2(N_SRC) | Source index to write |
| prio_wr_val | input | PRIO_W | Priority value to write |
| ack_rd | input | 1 | Acknowledge read strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the processor |
| ack_vec | output | $clog2(N_SRC) | Index of the winning source |
| cur_prio | output | PRIO_W | Current priority level |
| lifo_ovf | output | 1 | Sticky stack overflow flag |
| lifo_unf | output | 1 | Sticky stack underflow flag |

## Verification
The bench targets equal-priority ties and checks that the lowest index wins. An arbiter that scanned in the other direction, or replaced the winner on a tie, would report the higher index.

It checks that a masked source comes back after the priority is restored. A design that cleared sources on acknowledge would leave irq_req low at that point.

It also drives an acknowledge and an eoi in the same cycle, and an eoi on an empty stack. Wrong handling of either shows up as a wrong cur_prio or a missing underflow flag.

A second instance with a two-entry stack is pushed past its depth. The bench then checks the value the following pop restores. A design that overwrote the top on overflow would restore the newest level instead of the older one that was kept.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   // Number of bits needed to count 0..depth inclusive
   function automatic int cnt_bits(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
   parameter int N_SRC  = 16,
   parameter int PRIO_W = 4,
   localparam int IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]             pend,
   input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
   output logic [IDX_W-1:0]             win_idx,
   output logic [PRIO_W-1:0]            win_prio
);
   // Ascending scan with a strict compare: on equal priority the lower index stays.
   always_comb begin
      win_idx  = '0;
      win_prio = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (pend[i] && (prio[i] > win_prio)) begin
            win_idx  = IDX_W'(i);
            win_prio = prio[i];
         end
      end
   end
endmodule

// File: rtl/sw_req_bank.sv
module sw_req_bank #(
   parameter int N_SW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_SW-1:0] set_stb,
   input  logic [N_SW-1:0] clr_stb,
   output logic [N_SW-1:0] req_q
);
   for (genvar k = 0; k < N_SW; k++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          req_q[k] <= 1'b0;
         else if (set_stb[k]) req_q[k] <= 1'b1;
         else if (clr_stb[k]) req_q[k] <= 1'b0;
      end

      // R10
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_stb[k] |=> req_q[k]);
      // R10
      clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_stb[k] && !set_stb[k]) |=> !req_q[k]);
   end
endmodule

// File: rtl/prio_lifo.sv
module prio_lifo
   import prio_irq_pkg::*;
#(
   parameter int DEPTH  = 15,
   parameter int PRIO_W = 4,
   localparam int CNT_W = cnt_bits(DEPTH),
   localparam int SLOTS = 1 << CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PRIO_W-1:0] push_val,
   input  logic              pop,
   output logic [PRIO_W-1:0] top_val,
   output logic              empty,
   output logic              ovf,
   output logic              unf
);
   logic [PRIO_W-1:0] mem [SLOTS];
   logic [CNT_W-1:0]  cnt;
   logic              full;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));
   assign top_val = empty ? '0 : mem[cnt - 1'b1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
         unf <= 1'b0;
      end else if (push) begin
         if (full) ovf <= 1'b1;
         else      cnt <= cnt + 1'b1;
      end else if (pop) begin
         if (empty) unf <= 1'b1;
         else       cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[cnt] <= push_val;
   end

   // R8
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> ovf);
   // R8
   ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> $stable(top_val));
   // R7
   unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && empty) |=> unf);
   // R7
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf |=> unf);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int N_SRC       = 16,
   parameter int PRIO_W      = 4,
   parameter int N_SW        = 4,
   parameter int STACK_DEPTH = 15,
   localparam int IDX_W = $clog2(N_SRC),
   localparam int N_HW  = N_SRC - N_SW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_HW-1:0]   hw_irq,
   input  logic [N_SW-1:0]   sw_set,
   input  logic [N_SW-1:0]   sw_clr,
   input  logic              prio_wr_en,
   input  logic [IDX_W-1:0]  prio_wr_idx,
   input  logic [PRIO_W-1:0] prio_wr_val,
   input  logic              ack_rd,
   input  logic              eoi,
   output logic              irq_req,
   output logic [IDX_W-1:0]  ack_vec,
   output logic [PRIO_W-1:0] cur_prio,
   output logic              lifo_ovf,
   output logic              lifo_unf
);
   if (N_SW < 1 || N_HW < 1) begin : g_bad_split
      $error("prio_irq_ctrl: need at least one hardware and one software source");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("prio_irq_ctrl: STACK_DEPTH must be positive");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("prio_irq_ctrl: PRIO_W must be positive");
   end

   logic [N_SW-1:0]              sw_q;
   logic [N_SRC-1:0]             pend;
   logic [N_SRC-1:0][PRIO_W-1:0] src_prio;
   logic [IDX_W-1:0]             win_idx;
   logic [PRIO_W-1:0]            win_prio;
   logic [PRIO_W-1:0]            stk_top;
   logic                         stk_empty;
   logic                         do_ack;
   logic                         do_eoi;

   sw_req_bank #(.N_SW(N_SW)) u_sw (
      .clk(clk), .rst_n(rst_n),
      .set_stb(sw_set), .clr_stb(sw_clr), .req_q(sw_q)
   );

   assign pend = {sw_q, hw_irq};

   for (genvar s = 0; s < N_SRC; s++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            src_prio[s] <= '0;
         else if (prio_wr_en && (prio_wr_idx == IDX_W'(s)))
            src_prio[s] <= prio_wr_val;
      end
   end

   prio_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
      .pend(pend), .prio(src_prio), .win_idx(win_idx), .win_prio(win_prio)
   );

   assign irq_req = (win_prio > cur_prio);
   assign ack_vec = win_idx;
   assign do_ack  = ack_rd && irq_req;
   assign do_eoi  = eoi && !do_ack;

   prio_lifo #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) u_lifo (
      .clk(clk), .rst_n(rst_n),
      .push(do_ack), .push_val(cur_prio), .pop(do_eoi),
      .top_val(stk_top), .empty(stk_empty), .ovf(lifo_ovf), .unf(lifo_unf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cur_prio <= '0;
      else if (do_ack)                cur_prio <= win_prio;
      else if (do_eoi && !stk_empty)  cur_prio <= stk_top;
   end

   // R2
   req_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend[ack_vec] && (src_prio[ack_vec] > cur_prio)));
   // R4
   ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && irq_req) |=> (cur_prio == $past(src_prio[ack_vec])));
   // R5
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !irq_req && !eoi) |=> $stable(cur_prio));
   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lifo_ovf |=> lifo_ovf);
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
   localparam int N_SRC = 16;
   localparam int PW    = 4;
   localparam int NSW   = 4;
   localparam int NHW   = N_SRC - NSW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NHW-1:0] hw_irq = '0;
   logic [NSW-1:0] sw_set = '0, sw_clr = '0;
   logic           prio_wr_en = 1'b0;
   logic [3:0]     prio_wr_idx = '0;
   logic [PW-1:0]  prio_wr_val = '0;
   logic           ack_rd = 1'b0, eoi = 1'b0;
   logic           irq_req, irq_s;
   logic [3:0]     ack_vec, vec_s;
   logic [PW-1:0]  cur_prio, cur_s;
   logic           lifo_ovf, lifo_unf, ovf_s, unf_s;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   prio_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .sw_set(sw_set), .sw_clr(sw_clr),
      .prio_wr_en(prio_wr_en), .prio_wr_idx(prio_wr_idx), .prio_wr_val(prio_wr_val),
      .ack_rd(ack_rd), .eoi(eoi), .irq_req(irq_req), .ack_vec(ack_vec),
      .cur_prio(cur_prio), .lifo_ovf(lifo_ovf), .lifo_unf(lifo_unf)
   );

   prio_irq_ctrl #(.STACK_DEPTH(2)) dut_s (
      .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .sw_set(sw_set), .sw_clr(sw_clr),
      .prio_wr_en(prio_wr_en), .prio_wr_idx(prio_wr_idx), .prio_wr_val(prio_wr_val),
      .ack_rd(ack_rd), .eoi(eoi), .irq_req(irq_s), .ack_vec(vec_s),
      .cur_prio(cur_s), .lifo_ovf(ovf_s), .lifo_unf(unf_s)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_prio(input int idx, input int val);
      prio_wr_en = 1'b1; prio_wr_idx = 4'(idx); prio_wr_val = PW'(val);
      tick();
      prio_wr_en = 1'b0;
      #1;
   endtask

   task automatic do_ack();
      ack_rd = 1'b1; tick(); ack_rd = 1'b0; #1;
   endtask

   task automatic do_eoi();
      eoi = 1'b1; tick(); eoi = 1'b0; #1;
   endtask

   task automatic t_reset();
      check("R1 irq_req", irq_req, 0);
      check("R1 cur_prio", cur_prio, 0);
      check("R1 ovf", lifo_ovf, 0);
      check("R1 unf", lifo_unf, 0);
   endtask

   task automatic t_arbitration();
      hw_irq[3] = 1'b1; #1;
      check("R2 zero priority never requests", irq_req, 0);
      set_prio(3, 5);
      check("R11 R2 request after priority write", irq_req, 1);
      check("R3 single winner", ack_vec, 3);
      set_prio(7, 5); hw_irq[7] = 1'b1; #1;
      check("R3 tie goes to lower index", ack_vec, 3);
      set_prio(7, 9);
      check("R3 higher priority wins", ack_vec, 7);
   endtask

   task automatic t_nesting();
      do_ack();
      check("R4 cur_prio raised", cur_prio, 9);
      check("R2 masked by cur_prio", irq_req, 0);
      do_ack();
      check("R5 idle ack ignored", cur_prio, 9);
      set_prio(13, 12);
      sw_set[1] = 1'b1; tick(); sw_set[1] = 1'b0; #1;
      check("R10 software source requests", irq_req, 1);
      check("R10 software source index", ack_vec, 13);
      do_ack();
      check("R4 nested raise", cur_prio, 12);
      do_eoi();
      check("R6 pop restores outer level", cur_prio, 9);
      check("R9 uncleared source re-asserts", irq_req, 1);
      ack_rd = 1'b1; eoi = 1'b1; tick(); ack_rd = 1'b0; eoi = 1'b0; #1;
      check("R12 ack wins over eoi", cur_prio, 12);
      sw_clr[1] = 1'b1; tick(); sw_clr[1] = 1'b0; #1;
      check("R10 clear removes request", irq_req, 0);
      do_eoi();
      check("R6 first pop", cur_prio, 9);
      do_eoi();
      check("R6 second pop to base", cur_prio, 0);
      check("R9 hardware source re-asserts", irq_req, 1);
      check("R9 winner after restore", ack_vec, 7);
      check("R7 no underflow yet", lifo_unf, 0);
      do_eoi();
      check("R7 empty pop keeps cur_prio", cur_prio, 0);
      check("R7 underflow flag", lifo_unf, 1);
   endtask

   task automatic t_sw_strobes();
      set_prio(12, 14);
      sw_set[0] = 1'b1; sw_clr[0] = 1'b1; tick();
      sw_set[0] = 1'b0; sw_clr[0] = 1'b0; #1;
      check("R10 set wins over clear", ack_vec, 12);
      sw_clr[0] = 1'b1; tick(); sw_clr[0] = 1'b0; #1;
      check("R10 clear alone", ack_vec, 7);
   endtask

   task automatic t_overflow();
      do_ack();
      check("R4 ack level 9", cur_prio, 9);
      set_prio(3, 10);
      do_ack();
      check("R4 ack level 10", cur_s, 10);
      sw_set[0] = 1'b1; tick(); sw_set[0] = 1'b0; #1;
      do_ack();
      check("R8 cur_prio raised despite full", cur_s, 14);
      check("R8 small stack overflow", ovf_s, 1);
      check("R8 deep stack no overflow", lifo_ovf, 0);
      do_eoi();
      check("R8 overflowing push discarded", cur_s, 9);
      check("R6 deep stack pop", cur_prio, 10);
      check("R8 overflow sticky", ovf_s, 1);
      check("R7 underflow sticky", lifo_unf, 1);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_arbitration();
      t_nesting();
      t_sw_strobes();
      t_overflow();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule